// File: doc/BRIEF.md
# Selectable-Period Watchdog Timer

This block guards a running system against a stalled program. While enabled it counts system clocks. When the count reaches the power-of-two period picked by a two-bit select input, it raises a timeout flag. Software then has a fixed grace window of 2^EXT_W clocks (512 by default) in which a restart strobe still saves the system. If no restart arrives in that window, the block issues a one-clock reset pulse. The pulse also clears the flag and starts the next period from zero.

Software calls for a restart ("kicks" the watchdog) by strobing `kick_i` for one clock. The select bits and the enable are plain level inputs, held in a register elsewhere. A change to the select takes effect from the next clock. The block has no data stream, so none of its ports carries a handshake. The total time from a restart to a reset is 2^N + 2^EXT_W clocks, where N is the exponent picked by the select.

Top module: `sel_wdog`

## Requirements
- R1: Asserting `rst_n` low clears both outputs and both counters. After release with `en_i` high, `expired_o` rises exactly 2^N clock edges later.
- R2: `period_sel_i` picks N as follows: 0 gives EXP_SEL0, 1 gives EXP_SEL1, 2 gives EXP_SEL2 and 3 gives EXP_SEL3. `expired_o` rises exactly 2^N enabled clock edges after the last restart and is low on the edge before.
- R3: Once `expired_o` is high, it stays high for exactly 2^EXT_W clock edges unless a restart or disable occurs. `wdt_reset_o` stays low throughout that window.
- R4: `wdt_reset_o` is a pulse exactly one clock wide. It rises on the edge where `expired_o` falls. A new period starts then, so the following pulse comes 2^N + 2^EXT_W edges later.
- R5: `kick_i` high at a clock edge clears the counters and `expired_o`, and suppresses `wdt_reset_o`, including during the grace window. Timing restarts from that edge.
- R6: While `en_i` is low, both counters are held at zero and neither output is asserted. Counting restarts from zero once `en_i` returns high.
- R7: With default parameters the exponents are 14, 16, 18 and 21 and the grace window is 512 clocks. Select 0 therefore flags at 16384 edges and resets at 16896 edges.
- R8: `expired_o` and `wdt_reset_o` are never high in the same cycle.
- R9: Lowering `period_sel_i` mid-count takes effect on the next carry into bit N of the running count. For example, a count of 20 switched to N=3 flags at edge 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Watchdog enable; low holds everything idle |
| period_sel_i | input | 2 | Period select, picks exponent N |
| kick_i | input | 1 | Restart strobe from software |
| expired_o | output | 1 | Timeout flag, high during the grace window |
| wdt_reset_o | output | 1 | One-clock system reset request |

## Verification
A wrong value in the main counter shows at the ports as a flag that rises early or late by exactly the error. It is visible at the first expiry, at most 2^N clocks after the fault. A wrong grace counter shifts or suppresses the reset pulse, which shows within 2^EXT_W clocks of the flag rising. A flag that fails to clear shows on the edge after a restart or a disable. The bench therefore samples the exact edges on either side of each expected transition, for every select value.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef logic [1:0] wdt_sel_t;

  localparam int unsigned WDT_TAPS = 4;

  function automatic int unsigned wdt_max4(input int unsigned a, input int unsigned b,
                                           input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic int unsigned wdt_pick(input int unsigned idx,
                                           input int unsigned a, input int unsigned b,
                                           input int unsigned c, input int unsigned d);
    case (idx)
      0:       return a;
      1:       return b;
      2:       return c;
      default: return d;
    endcase
  endfunction

endpackage

// File: rtl/wdt_base_counter.sv
module wdt_base_counter #(
  parameter int unsigned CNT_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= cnt_q + CNT_ONE;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/wdt_tap_select.sv
module wdt_tap_select
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W    = 21,
  parameter int unsigned EXP_SEL0 = 14,
  parameter int unsigned EXP_SEL1 = 16,
  parameter int unsigned EXP_SEL2 = 18,
  parameter int unsigned EXP_SEL3 = 21
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  wdt_sel_t         sel_i,
  output logic             carry_o
);

  logic [WDT_TAPS-1:0] tap_carry;

  // Each tap is high on the cycle whose increment carries into bit E.
  for (genvar gi = 0; gi < WDT_TAPS; gi++) begin : g_tap
    localparam int unsigned E = wdt_pick(gi, EXP_SEL0, EXP_SEL1, EXP_SEL2, EXP_SEL3);
    assign tap_carry[gi] = &cnt_i[E-1:0];
  end

  assign carry_o = tap_carry[sel_i];

endmodule

// File: rtl/wdt_grace.sv
module wdt_grace #(
  parameter int unsigned EXT_W = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_i,
  input  logic arm_i,
  output logic flag_o,
  output logic fire_o
);

  localparam logic [EXT_W-1:0] EXT_ONE = EXT_W'(1);

  logic [EXT_W-1:0] ext_q;
  logic             flag_q;
  logic             fire_q;
  logic             last_c;

  assign last_c = !stop_i && flag_q && (&ext_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q  <= '0;
      flag_q <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= last_c;
      if (stop_i) begin
        ext_q  <= '0;
        flag_q <= 1'b0;
      end else if (arm_i) begin
        ext_q  <= '0;
        flag_q <= 1'b1;
      end else if (flag_q) begin
        if (&ext_q) begin
          ext_q  <= '0;
          flag_q <= 1'b0;
        end else begin
          ext_q <= ext_q + EXT_ONE;
        end
      end
    end
  end

  assign flag_o = flag_q;
  assign fire_o = fire_q;

endmodule

// File: rtl/sel_wdog.sv
module sel_wdog
  import wdt_pkg::*;
#(
  parameter int unsigned EXP_SEL0 = 14,
  parameter int unsigned EXP_SEL1 = 16,
  parameter int unsigned EXP_SEL2 = 18,
  parameter int unsigned EXP_SEL3 = 21,
  parameter int unsigned EXT_W    = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic [1:0] period_sel_i,
  input  logic       kick_i,
  output logic       expired_o,
  output logic       wdt_reset_o
);

  localparam int unsigned CNT_W = wdt_max4(EXP_SEL0, EXP_SEL1, EXP_SEL2, EXP_SEL3);

  logic [CNT_W-1:0] base_cnt;
  logic             carry_sel;
  logic             stop_all;
  logic             base_run;
  logic             arm_grace;
  logic             flag_q;
  logic             fire_q;

  assign stop_all  = !en_i || kick_i;
  assign base_run  = !stop_all && !flag_q;
  assign arm_grace = base_run && carry_sel;

  wdt_base_counter #(.CNT_W(CNT_W)) u_base (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (stop_all || arm_grace),
    .run_i (base_run),
    .cnt_o (base_cnt)
  );

  wdt_tap_select #(
    .CNT_W    (CNT_W),
    .EXP_SEL0 (EXP_SEL0),
    .EXP_SEL1 (EXP_SEL1),
    .EXP_SEL2 (EXP_SEL2),
    .EXP_SEL3 (EXP_SEL3)
  ) u_tap (
    .cnt_i   (base_cnt),
    .sel_i   (wdt_sel_t'(period_sel_i)),
    .carry_o (carry_sel)
  );

  wdt_grace #(.EXT_W(EXT_W)) u_grace (
    .clk    (clk),
    .rst_n  (rst_n),
    .stop_i (stop_all),
    .arm_i  (arm_grace),
    .flag_o (flag_q),
    .fire_o (fire_q)
  );

  assign expired_o   = flag_q;
  assign wdt_reset_o = fire_q;

endmodule

// File: rtl/sel_wdog_chk.sv
module sel_wdog_chk (
  input logic clk,
  input logic rst_n,
  input logic en_i,
  input logic kick_i,
  input logic expired_o,
  input logic wdt_reset_o
);

  // R4: reset request lasts one clock only
  p_pulse_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset_o |=> !wdt_reset_o);

  // R4: a reset request is always preceded by the grace flag
  p_pulse_after_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_reset_o) |-> $past(expired_o));

  // R5: a restart clears flag and suppresses reset
  p_kick_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> (!expired_o && !wdt_reset_o));

  // R6: disabled means silent
  p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!expired_o && !wdt_reset_o));

  // R3: flag holds until reset pulse, restart or disable
  p_flag_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_o && en_i && !kick_i) |=> (expired_o || wdt_reset_o));

  // R2: flag only rises from an enabled, unrestarted cycle
  p_rise_needs_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired_o) |-> ($past(en_i) && !$past(kick_i)));

  // R8: outputs exclusive
  always_comb begin
    if (rst_n) begin
      a_exclusive_r8: assert (!(expired_o && wdt_reset_o));
    end
  end

endmodule

bind sel_wdog sel_wdog_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en_i        (en_i),
  .kick_i      (kick_i),
  .expired_o   (expired_o),
  .wdt_reset_o (wdt_reset_o)
);

// File: tb/sel_wdog_bench.sv
`timescale 1ns/1ps
module sel_wdog_bench;

  localparam int unsigned X0 = 3;
  localparam int unsigned X1 = 4;
  localparam int unsigned X2 = 5;
  localparam int unsigned X3 = 7;
  localparam int unsigned XW = 3;
  localparam int GR = 1 << XW;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_i = 1'b0;
  logic [1:0] period_sel_i = 2'd0;
  logic       kick_i = 1'b0;
  logic       expired_o, wdt_reset_o;
  logic       d_expired, d_reset;

  int checks = 0;
  int errors = 0;
  int cur = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sel_wdog #(.EXP_SEL0(X0), .EXP_SEL1(X1), .EXP_SEL2(X2), .EXP_SEL3(X3), .EXT_W(XW)) u_sel_wdog (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .period_sel_i(period_sel_i),
    .kick_i(kick_i), .expired_o(expired_o), .wdt_reset_o(wdt_reset_o)
  );

  sel_wdog u_sel_wdog_dflt (
    .clk(clk), .rst_n(rst_n), .en_i(1'b1), .period_sel_i(2'd0),
    .kick_i(1'b0), .expired_o(d_expired), .wdt_reset_o(d_reset)
  );

  function automatic int period_of(input int s);
    case (s)
      0: return 1 << X0;
      1: return 1 << X1;
      2: return 1 << X2;
      default: return 1 << X3;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // move to just after clock edge number n, counted from the last restart
  task automatic go_to(input int n);
    while (cur < n) begin
      @(posedge clk);
      #1;
      cur++;
      if (expired_o && wdt_reset_o) chk("R8", "both outputs high", 1, 0);
    end
  endtask

  task automatic kick();
    @(negedge clk);
    kick_i = 1'b1;
    @(posedge clk);
    #1;
    @(negedge clk);
    kick_i = 1'b0;
    cur = 0;
  endtask

  initial begin
    #1_600_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: bench hung, actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int p;
    // R1 reset state
    en_i = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "expired in reset", int'(expired_o), 0);
    chk("R1", "reset out in reset", int'(wdt_reset_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    cur = 0;
    go_to((1 << X0) - 1);
    chk("R1", "flag before first expiry", int'(expired_o), 0);
    go_to(1 << X0);
    chk("R1", "flag at first expiry", int'(expired_o), 1);

    // R7 default instance, select 0, running since reset release
    go_to(16383);
    chk("R7", "default flag at 16383", int'(d_expired), 0);
    go_to(16384);
    chk("R7", "default flag at 16384", int'(d_expired), 1);
    go_to(16895);
    chk("R7", "default reset at 16895", int'(d_reset), 0);
    chk("R7", "default flag at 16895", int'(d_expired), 1);
    go_to(16896);
    chk("R7", "default reset at 16896", int'(d_reset), 1);
    go_to(16897);
    chk("R7", "default reset at 16897", int'(d_reset), 0);

    // R2 R3 R4: sweep every select value
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      period_sel_i = 2'(s);
      kick();
      p = period_of(s);
      go_to(p - 1);
      chk("R2", $sformatf("sel %0d flag before period", s), int'(expired_o), 0);
      go_to(p);
      chk("R2", $sformatf("sel %0d flag at period", s), int'(expired_o), 1);
      for (int k = 1; k < GR; k++) begin
        go_to(p + k);
        chk("R3", $sformatf("sel %0d grace flag k=%0d", s, k), int'(expired_o), 1);
        chk("R3", $sformatf("sel %0d grace reset k=%0d", s, k), int'(wdt_reset_o), 0);
      end
      go_to(p + GR);
      chk("R4", $sformatf("sel %0d reset pulse", s), int'(wdt_reset_o), 1);
      chk("R4", $sformatf("sel %0d flag drops", s), int'(expired_o), 0);
      go_to(p + GR + 1);
      chk("R4", $sformatf("sel %0d pulse width", s), int'(wdt_reset_o), 0);
      go_to(2 * p + GR - 1);
      chk("R4", $sformatf("sel %0d second flag early", s), int'(expired_o), 0);
      go_to(2 * (p + GR) - 1);
      chk("R4", $sformatf("sel %0d second reset early", s), int'(wdt_reset_o), 0);
      go_to(2 * (p + GR));
      chk("R4", $sformatf("sel %0d second reset", s), int'(wdt_reset_o), 1);
    end

    // R5: restart inside grace window, at each grace offset
    @(negedge clk);
    period_sel_i = 2'd1;
    p = period_of(1);
    for (int k = 0; k < GR; k++) begin
      kick();
      go_to(p + k);
      kick();
      chk("R5", $sformatf("flag cleared by kick k=%0d", k), int'(expired_o), 0);
      chk("R5", $sformatf("no reset after kick k=%0d", k), int'(wdt_reset_o), 0);
      go_to(p - 1);
      chk("R5", $sformatf("flag after kick early k=%0d", k), int'(expired_o), 0);
      go_to(p);
      chk("R5", $sformatf("flag after kick on time k=%0d", k), int'(expired_o), 1);
    end

    // R6: disable holds everything idle
    kick();
    go_to(p / 2);
    @(negedge clk);
    en_i = 1'b0;
    for (int k = 0; k < 3 * (p + GR); k++) begin
      @(posedge clk);
      #1;
      if (expired_o || wdt_reset_o)
        chk("R6", "output while disabled", int'({expired_o, wdt_reset_o}), 0);
    end
    chk("R6", "idle after disable", int'({expired_o, wdt_reset_o}), 0);
    @(negedge clk);
    en_i = 1'b1;
    cur = 0;
    go_to(p - 1);
    chk("R6", "restart from zero early", int'(expired_o), 0);
    go_to(p);
    chk("R6", "restart from zero on time", int'(expired_o), 1);

    // R9: lower the select mid-count
    @(negedge clk);
    period_sel_i = 2'd3;
    kick();
    go_to(20);
    @(negedge clk);
    period_sel_i = 2'd0;
    go_to(23);
    chk("R9", "flag before carry into bit 3", int'(expired_o), 0);
    go_to(24);
    chk("R9", "flag at carry into bit 3", int'(expired_o), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule